// File: doc/BRIEF.md
# Zero-Data Detector Flag

This block watches the stream of left/right sample pairs delivered by an upstream serial receiver and raises an active-high flag once the input has carried nothing but silence for a long stretch. A pair is strobed in with a one-cycle valid pulse on the system clock. The block counts how many all-zero pairs arrive in a row. When the run reaches the threshold, 2^14 pairs by default, the flag rises. It stays high until a pair with any nonzero bit arrives.

After reset the flag is also held high, so that downstream logic treats the channel as silent until real data starts. This startup interval ends with the first valid pair after reset, whatever its value. From then on the flag depends only on the zero-run count. Any muting that the flag may trigger lies outside this block.

Top module: `zero_data_flag`

## Requirements
- R1: While reset is applied, and from the release of reset until the first valid pair, `zero_flag` is 1.
- R2: A pair counts as zero only if every bit of both 16-bit samples is 0. A pair whose left or right sample alone is nonzero breaks the run.
- R3: A valid pair with a nonzero sample clears the run. `zero_flag` is 0 in the cycle after that pair is strobed.
- R4: The first valid pair after reset ends the startup interval. If that pair is all-zero and no run has built up, `zero_flag` is 0 in the following cycle.
- R5: `zero_flag` becomes 1 in the cycle after the 16384th consecutive all-zero pair. After 16383 such pairs it is still 0.
- R6: Cycles with `pair_vld` low neither advance nor break the run, whatever values sit on the sample inputs.
- R7: The run count saturates. Further all-zero pairs after the threshold keep `zero_flag` at 1.
- R8: Reset applied in the middle of operation discards the run and returns the block to the startup interval with `zero_flag` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_vld | input | 1 | One-cycle strobe marking a new left/right pair |
| left_smp | input | 16 | Left-channel sample, two's complement |
| right_smp | input | 16 | Right-channel sample, two's complement |
| zero_flag | output | 1 | High during startup and after a long all-zero run |

## Verification
The hardest condition to reach is the exact threshold edge: the flag must stay low after 16383 zero pairs and rise after the 16384th. The stimulus therefore strobes long unbroken runs, with idle cycles inserted that carry junk data on the sample buses. A behavioural model counts the pairs and compares its flag with the design's on every clock. The saturated state is held with extra zero pairs and then broken by single-channel nonzero pairs. A reset is also applied while the flag is high.

// File: rtl/zdf_pkg.sv
// Shared definitions for the zero-data detector.
// Assumes: two audio channels delivered together as one pair.
package zdf_pkg;
    localparam int NUM_CH = 2;

    // Whether the block is still waiting for its first pair.
    typedef enum logic {
        PH_STARTUP = 1'b1,
        PH_RUN     = 1'b0
    } zdf_phase_e;
endpackage

// File: rtl/zdf_pair_zero.sv
// Reports whether every channel sample of the present pair is all-zero.
// Assumes: samples are presented packed, one SAMPLE_W slice per channel.
module zdf_pair_zero #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 2
) (
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples,
    output logic                            pair_zero
);
    logic [NUM_CH-1:0] ch_nonzero;

    // One OR-reduction per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_nonzero[c] = |samples[c];
    end

    // The pair is zero only when no channel has a set bit.
    always_comb begin
        pair_zero = ~|ch_nonzero;
    end
endmodule

// File: rtl/zdf_run_counter.sv
// Saturating count of consecutive all-zero pairs; reports threshold reach.
// Assumes: pair_vld is a single-cycle strobe; synchronous active-low reset.
module zdf_run_counter #(
    parameter int RUN_LEN = 16384,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_vld,
    input  logic             pair_zero,
    output logic [CNT_W-1:0] run_cnt,
    output logic             run_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    // Advance on zero pairs up to the limit, clear on data, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (pair_vld) begin
            if (!pair_zero) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + CNT_W'(1);
            end
        end
    end

    // Threshold comparison.
    always_comb begin
        run_full = (run_cnt == CNT_MAX);
    end

    p_clear_on_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && !pair_zero |=> run_cnt == '0);

    p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && pair_zero && !run_full |=> run_cnt == $past(run_cnt) + CNT_W'(1));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |=> $stable(run_cnt));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_full && pair_vld && pair_zero |=> run_full);
endmodule

// File: rtl/zdf_startup.sv
// Tracks the startup interval: set by reset, left on the first valid pair.
// Assumes: synchronous active-low reset.
module zdf_startup
    import zdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pair_vld,
    output logic in_startup
);
    zdf_phase_e phase_q;

    // Enter startup on reset; leave permanently on the first pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STARTUP;
        end else if (pair_vld) begin
            phase_q <= PH_RUN;
        end
    end

    // Decode the phase for the flag logic.
    always_comb begin
        in_startup = (phase_q == PH_STARTUP);
    end

    p_leave_startup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !in_startup);

    p_no_reentry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_startup |=> !in_startup);

    p_reset_enters_r8: assert property (@(posedge clk)
        !rst_n |=> in_startup);
endmodule

// File: rtl/zero_data_flag.sv
// Zero-data detector: flag high during startup or after a long zero run.
// Assumes: one pair strobe per sample period; synchronous active-low reset.
module zero_data_flag #(
    parameter int SAMPLE_W = 16,
    parameter int RUN_LEN  = 16384
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_vld,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic                zero_flag
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [zdf_pkg::NUM_CH-1:0][SAMPLE_W-1:0] samples;
    logic                                     pair_zero;
    logic [CNT_W-1:0]                         run_cnt;
    logic                                     run_full;
    logic                                     in_startup;

    // Pack the two channels for the per-channel detector.
    always_comb begin
        samples[0] = left_smp;
        samples[1] = right_smp;
    end

    zdf_pair_zero #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_CH   (zdf_pkg::NUM_CH)
    ) u_pair_zero (
        .samples   (samples),
        .pair_zero (pair_zero)
    );

    zdf_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) u_run_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_vld  (pair_vld),
        .pair_zero (pair_zero),
        .run_cnt   (run_cnt),
        .run_full  (run_full)
    );

    zdf_startup u_startup (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_vld   (pair_vld),
        .in_startup (in_startup)
    );

    // Flag from registered state only.
    always_comb begin
        zero_flag = in_startup | run_full;
    end

    p_reset_flag_r1: assert property (@(posedge clk)
        !rst_n |=> zero_flag);

    p_flag_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && !pair_zero |=> !zero_flag);

    p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && ((left_smp == '0) != (right_smp == '0)) |=> run_cnt == '0);
endmodule

// File: tb/zero_data_flag_tb.sv
module zero_data_flag_tb;
    localparam int RUN = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_vld = 1'b0;
    logic [15:0] left_smp = 16'h0;
    logic [15:0] right_smp = 16'h0;
    logic        zero_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string phase    = "R1";

    // Behavioural reference state.
    bit m_start = 1'b1;
    int m_run   = 0;

    zero_data_flag u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_vld  (pair_vld),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .zero_flag (zero_flag)
    );

    always #2.5 clk = ~clk;

    // Update the model at each edge, then compare shortly after.
    always @(posedge clk) begin
        bit exp;
        if (!rst_n) begin
            m_start = 1'b1;
            m_run   = 0;
        end else if (pair_vld) begin
            m_start = 1'b0;
            if (left_smp == 16'h0 && right_smp == 16'h0)
                m_run = (m_run < RUN) ? m_run + 1 : RUN;
            else
                m_run = 0;
        end
        #1;
        exp = m_start || (m_run >= RUN);
        n_checks++;
        if (zero_flag !== exp) begin
            n_fail++;
            $display("FAIL %s: zero_flag=%0b expected %0b (run=%0d)", phase, zero_flag, exp, m_run);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic pair(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        pair_vld  = 1'b1;
        left_smp  = l;
        right_smp = r;
    endtask

    task automatic idle(input int n, input logic [15:0] l, input logic [15:0] r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pair_vld  = 1'b0;
            left_smp  = l;
            right_smp = r;
        end
    endtask

    // Zero pairs, with junk-carrying idle cycles between some of them (R6).
    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) begin
            pair(16'h0, 16'h0);
            if (i % 997 == 5) idle(2, 16'h8001, 16'h7FFF);
        end
    endtask

    initial begin
        phase = "R1";
        idle(4, 16'h1234, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(6, 16'h5555, 16'hAAAA);  // R1/R6: idle junk keeps startup

        phase = "R4";
        pair(16'h0, 16'h0);
        idle(2, 16'h0, 16'h0);

        phase = "R5";
        zeros(RUN - 2);               // one already counted, totals 16383
        idle(3, 16'hFFFF, 16'h0);     // R5/R6: still low
        pair(16'h0, 16'h0);           // 16384th
        idle(2, 16'h0, 16'h0);

        phase = "R7";
        zeros(200);
        idle(2, 16'h0001, 16'h0001);

        phase = "R2";
        pair(16'h0001, 16'h0);        // left only nonzero
        idle(2, 16'h0, 16'h0);

        phase = "R5";
        zeros(RUN);
        idle(2, 16'h0, 16'h0);

        phase = "R2";
        pair(16'h0, 16'h8000);        // right only nonzero
        idle(1, 16'h0, 16'h0);

        phase = "R3";
        zeros(RUN + 10);
        pair(16'hFFFF, 16'hFFFF);
        idle(2, 16'h0, 16'h0);
        zeros(50);

        phase = "R8";
        zeros(RUN);
        idle(1, 16'h0, 16'h0);
        @(negedge clk);
        rst_n = 1'b0;
        idle(3, 16'h0, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4, 16'h0, 16'h0);
        phase = "R3";
        pair(16'h0042, 16'h0);
        idle(3, 16'h0, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule